// File: doc/BRIEF.md
# Infrared Pulse-Width Symbol Classifier

This block turns a demodulated infrared line into a stream of symbols. It takes the line as an already synchronised, active-high level and a sampling tick from an external programmable divider. It measures every high and every low period in tick units. Each period is checked against a set of programmable minimum/maximum windows. A high period paired with the low period that follows it is classified as a header, a repeat header, a logic 0, a logic 1 or a stop. A qualifying high followed by an over-long silence is classified as a burst. Anything else is classified as an error.

Each classified symbol is reported as a one-cycle strobe carrying a 3-bit code. Data bits are collected into a 32-bit register, together with a saturating count of the bits received since the last header. The window limits are plain input ports. Each one is held stable by the surrounding logic while a frame is in flight. The 10-bit header window also serves as the low-period window for a stop and as the silence timeout for a burst. A single 8-bit window serves the high period of every data bit and burst, and the low period of a logic 0.

Top module: `ir_pulse_classifier`

## Requirements
- R1: A period's measured length is the number of cycles with `tick` high, from the cycle in which the level begins up to but not including the cycle in which it ends. The 10-bit measure holds at 1023 instead of wrapping.
- R2: Every window test is inclusive at both limits (`lo <= length <= hi`). An 8-bit window never accepts a length above 255.
- R3: A high period within `hdr_hi_min..hdr_hi_max`, followed by a low period within `hdr_lo_min..hdr_lo_max`, gives code 1 (header). The same strobe clears `rx_data` and `bit_count` to zero.
- R4: A high period within the header-high window, followed by a low period within `rpt_lo_min..rpt_lo_max`, gives code 2 (repeat). `rx_data` and `bit_count` are left unchanged.
- R5: A high period within `bit_min..bit_max` gives a data bit when it is followed by a low period in one of two windows. A low period within `bit_min..bit_max` gives code 3 (logic 0). A low period within `one_lo_min..one_lo_max` gives code 4 (logic 1). The bit value is written to `rx_data[bit_count]` while `bit_count < 32`, so the first bit lands in bit 0. `bit_count` then increments, holding at 63.
- R6: A high period within `bit_min..bit_max`, followed by a low period within the header-high window that ends with a rising edge, gives code 6 (stop). At that strobe, `bit_count` shows the number of bits received since the last header.
- R7: A burst is reported when a high period within `bit_min..bit_max` is followed by a low period whose running length exceeds `hdr_hi_max` before any rising edge. The block strobes code 5 (burst) and waits idle for the next rising edge.
- R8: Error (code 7) is strobed in three cases. (a) A high period fits neither the header-high window nor the bit window; this is reported at its falling edge. (b) A pair matches no symbol; this is reported at the rising edge. (c) A header-qualified high is followed by a low that exceeds `hdr_hi_max`. After an error the block idles, ignores any high period already in progress, and restarts at the next rising edge.
- R9: When windows overlap, a pair is decoded by the first match in this order: header, repeat, logic 0, logic 1, stop.
- R10: `sym_valid` is high for exactly the cycle after the cycle holding the deciding edge or timeout. While it is high, `sym_code` is nonzero. While it is low, `sym_code` reads 0.
- R11: After reset, `sym_valid`, `sym_code`, `rx_data` and `bit_count` are all zero, and the block is idle, waiting for a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_in | input | 1 | Synchronised demodulated line, high = carrier present |
| tick | input | 1 | Sampling strobe from the external divider |
| hdr_hi_min | input | 10 | Lower limit of the header-high / stop-low window |
| hdr_hi_max | input | 10 | Upper limit of the header-high / stop-low window, also the burst timeout |
| hdr_lo_min | input | 8 | Lower limit of the header low window |
| hdr_lo_max | input | 8 | Upper limit of the header low window |
| rpt_lo_min | input | 8 | Lower limit of the repeat low window |
| rpt_lo_max | input | 8 | Upper limit of the repeat low window |
| bit_min | input | 8 | Lower limit of the shared bit window |
| bit_max | input | 8 | Upper limit of the shared bit window |
| one_lo_min | input | 8 | Lower limit of the logic-1 low window |
| one_lo_max | input | 8 | Upper limit of the logic-1 low window |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_code | output | 3 | Symbol code (0 idle, 1 header, 2 repeat, 3 logic 0, 4 logic 1, 5 burst, 6 stop, 7 error) |
| rx_data | output | 32 | Received bits, first bit in bit 0 |
| bit_count | output | 6 | Bits received since the last header, saturating |

## Verification
A rising edge that closes a pair also opens the next high period. In that one cycle, the block must classify the pair and also restart the counter, counting any tick in that cycle toward the new period. The bench provokes this by driving data bits back to back, with the tick high on every cycle and again with a divided tick whose phase falls on the edges. It judges the result by checking that each following symbol decodes exactly as its durations predict. The boundary lengths used in these runs are exactly one tick off a window limit, so a lost or doubled tick at the shared edge changes the decoded code.

// File: rtl/ir_sym_pkg.sv
// Package: shared widths, window indices and encodings of the classifier.
// Assumes: the bit counter is wide enough to hold DATA_W.
package ir_sym_pkg;
    localparam int CNT_W  = 10;  // period measure width (header-high window width)
    localparam int LIM_W  = 8;   // width of the narrow windows
    localparam int DATA_W = 32;  // received data register width
    localparam int BCNT_W = 6;   // bit counter width
    localparam int NWIN   = 5;   // number of windows

    // Window indices into the hit vector.
    localparam int W_HH = 0;     // header high, stop low, burst timeout
    localparam int W_HL = 1;     // header low
    localparam int W_RP = 2;     // repeat low
    localparam int W_D0 = 3;     // bit window (shared)
    localparam int W_D1 = 4;     // logic-1 low

    typedef enum logic [2:0] {
        SYM_NONE  = 3'd0,
        SYM_HDR   = 3'd1,
        SYM_RPT   = 3'd2,
        SYM_B0    = 3'd3,
        SYM_B1    = 3'd4,
        SYM_BURST = 3'd5,
        SYM_STOP  = 3'd6,
        SYM_ERR   = 3'd7
    } sym_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } state_e;
endpackage

// File: rtl/ir_period_meter.sv
// Period meter: detects edges of the synchronised line and counts ticks
// spent at the current level. The count restarts on each edge (counting a
// tick in the edge cycle) and holds at its maximum.
// Assumes: level is already synchronised to clk.
module ir_period_meter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level,
    input  logic         tick,
    output logic         rise,
    output logic         fall,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    logic level_q;

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    // Restart on an edge, otherwise count ticks up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (rise || fall)          count <= tick ? W'(1) : '0;
        else if (tick && count != CMAX) count <= count + W'(1);
    end
endmodule

// File: rtl/ir_window_cmp.sv
// Window comparator: flags a value lying inside [lo, hi], both ends inclusive.
// Assumes: narrower limits are zero-extended by the caller.
module ir_window_cmp #(
    parameter int W = 10
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // Inclusive range test.
    always_comb hit = (value >= lo) && (value <= hi);
endmodule

// File: rtl/ir_symbol_fsm.sv
// Symbol sequencer: tracks idle / high / low, qualifies each high period on
// its falling edge, and decodes the pair on the rising edge that ends the
// low period, or on a silence timeout. Emits a registered one-cycle strobe
// and also exposes the unregistered decision for the bit collector.
// Assumes: hit[] reflects the count of the period ending in an edge cycle.
module ir_symbol_fsm
    import ir_sym_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            fall,
    input  logic [CW-1:0]   count,
    input  logic [CW-1:0]   timeout_lim,
    input  logic [NWIN-1:0] hit,
    output logic            emit_d,
    output sym_e            code_d,
    output logic            sym_valid,
    output logic [2:0]      sym_code
);
    state_e st_q, st_d;
    logic   hh_q, hh_d;   // latched: high period fit header window
    logic   d0_q, d0_d;   // latched: high period fit bit window
    logic   over;

    // Silence timeout: the low period has run past the header-high limit.
    always_comb over = (count > timeout_lim);

    // Next-state and symbol decision.
    always_comb begin
        st_d   = st_q;
        hh_d   = hh_q;
        d0_d   = d0_q;
        emit_d = 1'b0;
        code_d = SYM_NONE;
        unique case (st_q)
            ST_IDLE: begin
                if (rise) st_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (fall) begin
                    if (hit[W_HH] || hit[W_D0]) begin
                        st_d = ST_LOW;
                        hh_d = hit[W_HH];
                        d0_d = hit[W_D0];
                    end else begin
                        emit_d = 1'b1;
                        code_d = SYM_ERR;
                        st_d   = ST_IDLE;
                    end
                end
            end
            ST_LOW: begin
                if (rise) begin
                    emit_d = 1'b1;
                    st_d   = ST_HIGH;
                    if (hh_q && hit[W_HL])      code_d = SYM_HDR;
                    else if (hh_q && hit[W_RP]) code_d = SYM_RPT;
                    else if (d0_q && hit[W_D0]) code_d = SYM_B0;
                    else if (d0_q && hit[W_D1]) code_d = SYM_B1;
                    else if (d0_q && hit[W_HH]) code_d = SYM_STOP;
                    else begin
                        code_d = SYM_ERR;
                        st_d   = ST_IDLE;
                    end
                end else if (over) begin
                    emit_d = 1'b1;
                    code_d = d0_q ? SYM_BURST : SYM_ERR;
                    st_d   = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and qualification flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            hh_q <= 1'b0;
            d0_q <= 1'b0;
        end else begin
            st_q <= st_d;
            hh_q <= hh_d;
            d0_q <= d0_d;
        end
    end

    // Registered symbol strobe and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_valid <= 1'b0;
            sym_code  <= 3'd0;
        end else begin
            sym_valid <= emit_d;
            sym_code  <= emit_d ? code_d : SYM_NONE;
        end
    end
endmodule

// File: rtl/ir_bit_collector.sv
// Bit collector: clears on a header, stores logic 0/1 symbols at the
// current bit index (first bit in bit 0) and counts bits with saturation.
// Assumes: BCNT_W can represent DATA_W; driven by the unregistered decision
// so that data and count update on the same edge as the strobe.
module ir_bit_collector
    import ir_sym_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  sym_e              code,
    output logic [DATA_W-1:0] rx_data,
    output logic [BCNT_W-1:0] bit_count
);
    localparam int                IDX_W = $clog2(DATA_W);
    localparam logic [BCNT_W-1:0] STORE_LIM = BCNT_W'(DATA_W);
    localparam logic [BCNT_W-1:0] BC_MAX = '1;

    logic is_bit;
    logic bit_val;

    // Classify the decision as a data bit and pick its value.
    always_comb begin
        is_bit  = emit && (code == SYM_B0 || code == SYM_B1);
        bit_val = (code == SYM_B1);
    end

    // Data register and saturating bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            bit_count <= '0;
        end else if (emit && code == SYM_HDR) begin
            rx_data   <= '0;
            bit_count <= '0;
        end else if (is_bit) begin
            if (bit_count < STORE_LIM)
                rx_data[bit_count[IDX_W-1:0]] <= bit_val;
            if (bit_count != BC_MAX)
                bit_count <= bit_count + BCNT_W'(1);
        end
    end
endmodule

// File: rtl/ir_pulse_classifier.sv
// Top: infrared pulse-width symbol classifier. Measures high/low periods in
// tick units, compares them against five programmable windows and reports
// symbols plus collected data bits.
// Assumes: ir_in synchronised, window limits stable while a frame runs.
module ir_pulse_classifier
    import ir_sym_pkg::*;
#(
    parameter int HH_W  = ir_sym_pkg::CNT_W,
    parameter int LW    = ir_sym_pkg::LIM_W,
    parameter int DW    = ir_sym_pkg::DATA_W,
    parameter int BCW   = ir_sym_pkg::BCNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ir_in,
    input  logic           tick,
    input  logic [HH_W-1:0] hdr_hi_min,
    input  logic [HH_W-1:0] hdr_hi_max,
    input  logic [LW-1:0]  hdr_lo_min,
    input  logic [LW-1:0]  hdr_lo_max,
    input  logic [LW-1:0]  rpt_lo_min,
    input  logic [LW-1:0]  rpt_lo_max,
    input  logic [LW-1:0]  bit_min,
    input  logic [LW-1:0]  bit_max,
    input  logic [LW-1:0]  one_lo_min,
    input  logic [LW-1:0]  one_lo_max,
    output logic           sym_valid,
    output logic [2:0]     sym_code,
    output logic [DW-1:0]  rx_data,
    output logic [BCW-1:0] bit_count
);
    localparam int CW  = HH_W;
    localparam int EXT = CW - LW;

    logic            rise, fall;
    logic [CW-1:0]   count;
    logic [CW-1:0]   wlo [NWIN];
    logic [CW-1:0]   whi [NWIN];
    logic [NWIN-1:0] hit;
    logic            emit_d;
    sym_e            code_d;

    // Gather window limits, zero-extending the narrow ones.
    always_comb begin
        wlo[W_HH] = hdr_hi_min;
        whi[W_HH] = hdr_hi_max;
        wlo[W_HL] = {{EXT{1'b0}}, hdr_lo_min};
        whi[W_HL] = {{EXT{1'b0}}, hdr_lo_max};
        wlo[W_RP] = {{EXT{1'b0}}, rpt_lo_min};
        whi[W_RP] = {{EXT{1'b0}}, rpt_lo_max};
        wlo[W_D0] = {{EXT{1'b0}}, bit_min};
        whi[W_D0] = {{EXT{1'b0}}, bit_max};
        wlo[W_D1] = {{EXT{1'b0}}, one_lo_min};
        whi[W_D1] = {{EXT{1'b0}}, one_lo_max};
    end

    ir_period_meter #(.W(CW)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ir_in),
        .tick  (tick),
        .rise  (rise),
        .fall  (fall),
        .count (count)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        ir_window_cmp #(.W(CW)) u_win (
            .value (count),
            .lo    (wlo[g]),
            .hi    (whi[g]),
            .hit   (hit[g])
        );
    end

    ir_symbol_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .fall        (fall),
        .count       (count),
        .timeout_lim (hdr_hi_max),
        .hit         (hit),
        .emit_d      (emit_d),
        .code_d      (code_d),
        .sym_valid   (sym_valid),
        .sym_code    (sym_code)
    );

    ir_bit_collector #(.DATA_W(DW), .BCNT_W(BCW)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit_d),
        .code      (code_d),
        .rx_data   (rx_data),
        .bit_count (bit_count)
    );
endmodule

// File: rtl/ir_pulse_classifier_chk.sv
// Checker: temporal properties of the classifier's ports, bound to the top.
module ir_pulse_classifier_chk #(
    parameter int DW  = 32,
    parameter int BCW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ir_in,
    input logic           sym_valid,
    input logic [2:0]     sym_code,
    input logic [DW-1:0]  rx_data,
    input logic [BCW-1:0] bit_count
);
    localparam int             IDX_W = $clog2(DW);
    localparam logic [BCW-1:0] BC_MAX = '1;
    localparam logic [BCW-1:0] DLIM = BCW'(DW);

    logic [BCW-1:0] bc_m1;
    always_comb bc_m1 = bit_count - BCW'(1);

    // R10
    strobe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> sym_code != 3'd0);
    // R10
    quiet_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |-> sym_code == 3'd0);
    // R3
    hdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == 3'd1) |-> (bit_count == '0 && rx_data == '0));
    // R4
    rpt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == 3'd2) |-> ($stable(rx_data) && $stable(bit_count)));
    // R5
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (sym_code == 3'd3 || sym_code == 3'd4) && $past(bit_count) != BC_MAX)
        |-> bit_count == $past(bit_count) + BCW'(1));
    // R5
    one_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == 3'd4 && bit_count != '0 && bit_count <= DLIM)
        |-> rx_data[bc_m1[IDX_W-1:0]]);
    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |-> $stable(bit_count));
    // R6
    pair_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code != 3'd5 && sym_code != 3'd7)
        |-> ($past(ir_in) && !$past(ir_in, 2)));
endmodule

bind ir_pulse_classifier ir_pulse_classifier_chk #(.DW(DW), .BCW(BCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_in     (ir_in),
    .sym_valid (sym_valid),
    .sym_code  (sym_code),
    .rx_data   (rx_data),
    .bit_count (bit_count)
);

// File: tb/test_ir_pulse_classifier.sv
module test_ir_pulse_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int NPAIR = 9;
    // Table: high length, low length, expected code at the closing rise.
    localparam int TB_H [NPAIR] = '{50, 4, 4, 4, 4, 3, 60, 40, 6};
    localparam int TB_L [NPAIR] = '{25, 4, 8, 4, 9, 6, 10, 15, 50};
    localparam int TB_E [NPAIR] = '{ 1, 3, 4, 3, 4, 3,  2,  2, 6};

    logic clk = 0, rst_n = 0, ir_in = 0, tick = 1;
    logic [9:0] hdr_hi_min = 10'd40, hdr_hi_max = 10'd60;
    logic [7:0] hdr_lo_min = 8'd20, hdr_lo_max = 8'd30;
    logic [7:0] rpt_lo_min = 8'd10, rpt_lo_max = 8'd15;
    logic [7:0] bit_min = 8'd3, bit_max = 8'd6;
    logic [7:0] one_lo_min = 8'd7, one_lo_max = 8'd9;
    logic        sym_valid;
    logic [2:0]  sym_code;
    logic [31:0] rx_data;
    logic [5:0]  bit_count;

    int total = 0, bad = 0, cyc = 0, tick_div = 1, tick_cnt = 0;
    int n_log = 0;
    int log_code [256];
    int log_bc   [256];

    ir_pulse_classifier i_ir_pulse_classifier (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .tick(tick),
        .hdr_hi_min(hdr_hi_min), .hdr_hi_max(hdr_hi_max),
        .hdr_lo_min(hdr_lo_min), .hdr_lo_max(hdr_lo_max),
        .rpt_lo_min(rpt_lo_min), .rpt_lo_max(rpt_lo_max),
        .bit_min(bit_min), .bit_max(bit_max),
        .one_lo_min(one_lo_min), .one_lo_max(one_lo_max),
        .sym_valid(sym_valid), .sym_code(sym_code),
        .rx_data(rx_data), .bit_count(bit_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick source: every cycle, or one in tick_div cycles.
    always @(negedge clk) begin
        if (tick_div <= 1) tick <= 1'b1;
        else begin
            tick_cnt <= (tick_cnt + 1) % tick_div;
            tick <= (tick_cnt == 0);
        end
    end

    // Symbol monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && sym_valid && n_log < 256) begin
            log_code[n_log] = int'(sym_code);
            log_bc[n_log]   = int'(bit_count);
            n_log = n_log + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic seg(input logic lvl, input int n);
        ir_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic pair(input int h, input int l);
        seg(1'b1, h);
        seg(1'b0, l);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid", sym_valid, 0);
        chk("R11 code", sym_code, 0);
        chk("R11 data", rx_data, 0);
        chk("R11 count", bit_count, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // Table walk: R3 R4 R5 R6 R7 R10, inclusive limits R2
        base = n_log;
        for (int i = 0; i < NPAIR; i++) pair(TB_H[i], TB_L[i]);
        pair(4, 80);
        for (int i = 0; i < NPAIR; i++)
            chk($sformatf("R2/R10 table entry %0d", i), log_code[base+i], TB_E[i]);
        chk("R7 burst after silence", log_code[base+NPAIR], 5);
        chk("R6 bit_count at stop", log_bc[base+NPAIR-1], 5);
        chk("R5 data LSB first", rx_data, 32'h0000000A);
        chk("R4 repeat keeps count", bit_count, 5);
        chk("R10 symbol count", n_log - base, NPAIR + 1);

        // R9: overlapping windows, logic 0 wins over logic 1; R3 clears count
        one_lo_min = 8'd5;
        base = n_log;
        pair(50, 25); pair(4, 5); pair(4, 80);
        chk("R9 priority logic0", log_code[base+1], 3);
        chk("R3 header clears count", bit_count, 1);
        chk("R3 header clears data", rx_data, 0);
        one_lo_min = 8'd7;

        // R8: error paths and recovery
        base = n_log;
        pair(39, 10);             // (a) high fits no window
        pair(50, 35);             // (b) pair unmatched
        pair(10, 10);             // ignored high
        pair(40, 20);             // header at inclusive minima (R2)
        pair(61, 10);             // (a) just above header max
        pair(50, 80);             // (c) timeout after header high
        chk("R8 error at fall", log_code[base], 7);
        chk("R8 error unmatched pair", log_code[base+1], 7);
        chk("R8 recovery header R2", log_code[base+2], 1);
        chk("R8 error above max", log_code[base+3], 7);
        chk("R8 error timeout", log_code[base+4], 7);
        chk("R8 no extra symbols", n_log - base, 5);

        // R1: divided tick, shared edge cycles
        tick_div = 4;
        repeat (8) @(negedge clk);
        base = n_log;
        pair(200, 100); pair(16, 32); pair(16, 300);
        chk("R1 divided header", log_code[base], 1);
        chk("R1 divided logic1", log_code[base+1], 4);
        chk("R1 divided burst R7", log_code[base+2], 5);
        tick_div = 1;
        repeat (4) @(negedge clk);

        // R1: saturation, over-long high reads as 1023
        hdr_hi_min = 10'd1000; hdr_hi_max = 10'd1023;
        base = n_log;
        seg(1'b1, 1100); seg(1'b0, 25); seg(1'b1, 4);
        hdr_hi_min = 10'd40; hdr_hi_max = 10'd60;
        seg(1'b0, 80);
        chk("R1 saturated header", log_code[base], 1);
        chk("R1 saturation then burst", log_code[base+1], 5);

        // R5: saturating bit count, storage stops at 32 bits
        pair(50, 25);
        for (int i = 0; i < 65; i++) pair(4, 8);
        pair(4, 80);
        chk("R5 count saturates", bit_count, 63);
        chk("R5 data all ones", rx_data, 32'hFFFFFFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule